// File: doc/BRIEF.md
# Floating-Point Pipeline Occupancy Controller

This block steers operation tags through a three-stage floating-point arithmetic pipeline. The stages are multiply, add and normalize, in that order. It does not compute any arithmetic result. A tag and a one-bit exception flag stand in for the datapath. An issuer offers operations over a valid/ready handshake, and each operation carries an operation class. The controller decides how long the first stage keeps the operation, based on its class. It withholds ready while that stage is occupied, and it announces each tag as it leaves the normalize stage.

Single-precision arithmetic streams at one per cycle. A double-precision multiply stays in the first stage for two cycles. A divide stays there for a parameterised number of iterations. Sustained throughput therefore follows the mix of operation classes. The add and normalize stages never stall, so operations always leave in the order they entered. A synchronous flush discards everything in flight.

Top module: `fpoc_pipe_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `fin_valid` is 0 and `iss_ready` is 1.
- R2: Class code 2'b00 (and the spare code 2'b11) is single-precision arithmetic. Its first-stage hold is one cycle. An operation accepted at clock edge n is presented on `fin_*` in the cycle that follows edge n+2. Such operations can be accepted on consecutive edges.
- R3: Class code 2'b01 is a double-precision multiply. It holds the first stage for two cycles, so `iss_ready` is 0 in the cycle after acceptance. The next operation can be accepted two edges later, and the multiply finishes in the cycle after edge n+3.
- R4: Class code 2'b10 is a divide. It holds the first stage for DIV_CYC cycles, so the next acceptance is DIV_CYC edges later. The divide finishes in the cycle after edge n+DIV_CYC+1.
- R5: The exception flag given at issue comes out unchanged on `fin_exc`, alongside its own tag.
- R6: A cycle with `flush` high empties all three stages at its edge. No flushed tag is ever finished. `iss_ready` is 0 during that cycle, so an offered operation is not taken.
- R7: Finished tags appear in acceptance order, with at most one per cycle, and each accepted, unflushed tag finishes exactly once.
- R8: `iss_ready` is 1 whenever `flush` is low and the first stage is empty or is in its last hold cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties every stage at the clock edge |
| iss_valid | input | 1 | Issuer offers an operation |
| iss_ready | output | 1 | Controller can take the offered operation |
| iss_cls | input | 2 | Operation class code |
| iss_tag | input | TAG_W | Tag of the offered operation |
| iss_exc | input | 1 | Exception flag that travels with the tag |
| fin_valid | output | 1 | A tag leaves the normalize stage this cycle |
| fin_tag | output | TAG_W | Finishing tag |
| fin_exc | output | 1 | Exception flag of the finishing tag |

## Verification
The bench measures the gap between acceptances after each class. A controller that stalls single-precision work, releases a double multiply after one cycle, or miscounts divide iterations by one shows up as a wrong acceptance cycle or a wrong finish cycle. Flushes are applied while an operation is in every stage, and also in the middle of a divide, with an operation offered during the flush. A controller that keeps a stage, accepts that offer, or keeps counting the divide would produce a tag the scoreboard never expected. Mixed class sequences check that finish order and the exception flag stay attached to the right tag.

// File: rtl/fpoc_pkg.sv
package fpoc_pkg;
  localparam int FP_STAGES = 3;

  typedef enum logic [1:0] {
    CLS_SP  = 2'b00,
    CLS_DPM = 2'b01,
    CLS_DIV = 2'b10,
    CLS_SPX = 2'b11
  } op_cls_e;
endpackage

// File: rtl/fpoc_head.sv
module fpoc_head
  import fpoc_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int DIV_CYC = 17,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             load,
  input  op_cls_e          cls,
  input  logic [TAG_W-1:0] tag,
  input  logic             exc,
  output logic             valid,
  output logic             last,
  output logic [TAG_W-1:0] tag_q,
  output logic             exc_q
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] hold_init;

  always_comb begin
    case (cls)
      CLS_DPM: hold_init = CNT_W'(1);
      CLS_DIV: hold_init = CNT_W'(DIV_CYC - 1);
      default: hold_init = '0;
    endcase
  end

  assign last = valid && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cnt   <= '0;
      tag_q <= '0;
      exc_q <= 1'b0;
    end else if (flush) begin
      valid <= 1'b0;
      cnt   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      cnt   <= hold_init;
      tag_q <= tag;
      exc_q <= exc;
    end else if (last) begin
      valid <= 1'b0;
    end else if (valid) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R4: an operation with iterations left stays in the first stage
  p_head_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (valid && cnt != '0 && !flush) |=> valid);
endmodule

// File: rtl/fpoc_stage.sv
module fpoc_stage #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             in_v,
  input  logic [TAG_W-1:0] in_tag,
  input  logic             in_exc,
  output logic             out_v,
  output logic [TAG_W-1:0] out_tag,
  output logic             out_exc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_v   <= 1'b0;
      out_tag <= '0;
      out_exc <= 1'b0;
    end else begin
      out_v   <= in_v && !flush;
      out_tag <= in_tag;
      out_exc <= in_exc;
    end
  end
endmodule

// File: rtl/fpoc_pipe_ctrl.sv
module fpoc_pipe_ctrl
  import fpoc_pkg::*;
#(
  parameter int TAG_W   = 6,
  parameter int DIV_CYC = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             iss_valid,
  output logic             iss_ready,
  input  logic [1:0]       iss_cls,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             iss_exc,
  output logic             fin_valid,
  output logic [TAG_W-1:0] fin_tag,
  output logic             fin_exc
);
  localparam int NUM_TAIL = FP_STAGES - 1;
  localparam int CNT_W    = (DIV_CYC < 3) ? 1 : $clog2(DIV_CYC);

  logic             head_valid, head_last;
  logic [TAG_W-1:0] head_tag;
  logic             head_exc;
  logic             accept;
  op_cls_e          cls_in;

  logic             st_v   [NUM_TAIL+1];
  logic [TAG_W-1:0] st_tag [NUM_TAIL+1];
  logic             st_exc [NUM_TAIL+1];

  assign cls_in    = op_cls_e'(iss_cls);
  assign iss_ready = !flush && (!head_valid || head_last);
  assign accept    = iss_valid && iss_ready;

  fpoc_head #(.TAG_W(TAG_W), .DIV_CYC(DIV_CYC), .CNT_W(CNT_W)) u_head (
    .clk   (clk),
    .rst   (rst),
    .flush (flush),
    .load  (accept),
    .cls   (cls_in),
    .tag   (iss_tag),
    .exc   (iss_exc),
    .valid (head_valid),
    .last  (head_last),
    .tag_q (head_tag),
    .exc_q (head_exc)
  );

  assign st_v[0]   = head_last;
  assign st_tag[0] = head_tag;
  assign st_exc[0] = head_exc;

  for (genvar g = 0; g < NUM_TAIL; g++) begin : g_tail
    fpoc_stage #(.TAG_W(TAG_W)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .in_v    (st_v[g]),
      .in_tag  (st_tag[g]),
      .in_exc  (st_exc[g]),
      .out_v   (st_v[g+1]),
      .out_tag (st_tag[g+1]),
      .out_exc (st_exc[g+1])
    );
  end

  assign fin_valid = st_v[NUM_TAIL];
  assign fin_tag   = st_tag[NUM_TAIL];
  assign fin_exc   = st_exc[NUM_TAIL];

  // R1: nothing finishes right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> !fin_valid);

  // R2 and R5: single-precision op finishes two edges after acceptance with its flag
  p_sp_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (accept && (cls_in == CLS_SP || cls_in == CLS_SPX)) ##1 !flush ##1 !flush
    |=> (fin_valid && fin_tag == $past(iss_tag, 3) && fin_exc == $past(iss_exc, 3)));

  // R3: double multiply finishes three edges after acceptance
  p_dp_latency_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && cls_in == CLS_DPM) ##1 !flush ##1 !flush ##1 !flush
    |=> (fin_valid && fin_tag == $past(iss_tag, 4)));

  // R3: issue is refused in the cycle after a double multiply is taken
  p_dp_stall_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && cls_in == CLS_DPM) |=> !iss_ready);

  // R4: issue is refused in the cycle after a divide is taken
  p_div_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (accept && cls_in == CLS_DIV) |=> !iss_ready);

  // R6: a flush leaves nothing to finish in the next cycle
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !fin_valid);
endmodule

// File: tb/fpoc_pipe_ctrl_tb.sv
module fpoc_pipe_ctrl_tb;
  localparam int TAG_W   = 6;
  localparam int DIV_CYC = 17;
  localparam int WD_MAX  = 20000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             flush = 1'b0;
  logic             iss_valid = 1'b0;
  logic             iss_ready;
  logic [1:0]       iss_cls = 2'b00;
  logic [TAG_W-1:0] iss_tag = '0;
  logic             iss_exc = 1'b0;
  logic             fin_valid;
  logic [TAG_W-1:0] fin_tag;
  logic             fin_exc;

  typedef struct {
    logic [TAG_W-1:0] tag;
    logic             exc;
    int               due;
    string            req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  fpoc_pipe_ctrl #(.TAG_W(TAG_W), .DIV_CYC(DIV_CYC)) u_dut (
    .clk(clk), .rst(rst), .flush(flush),
    .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_cls(iss_cls),
    .iss_tag(iss_tag), .iss_exc(iss_exc),
    .fin_valid(fin_valid), .fin_tag(fin_tag), .fin_exc(fin_exc)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int lat(input logic [1:0] c);
    case (c)
      2'b01:   return 4;
      2'b10:   return DIV_CYC + 2;
      default: return 3;
    endcase
  endfunction

  // driver: offers one op, waits for acceptance, pushes the expectation
  task automatic issue(input logic [1:0] c, input logic [TAG_W-1:0] t,
                       input logic e, input string req, output int acc);
    exp_t it;
    @(negedge clk);
    iss_valid = 1'b1; iss_cls = c; iss_tag = t; iss_exc = e;
    #1;
    while (!iss_ready) begin
      @(negedge clk);
      #1;
    end
    acc = cyc + 1;
    it.tag = t; it.exc = e; it.due = acc + lat(c) - 1; it.req = req;
    q.push_back(it);
    @(posedge clk);
    #1;
    iss_valid = 1'b0;
  endtask

  task automatic flush_now();
    @(negedge clk);
    flush = 1'b1; iss_valid = 1'b1; iss_cls = 2'b00; iss_tag = '1; iss_exc = 1'b1;
    #1;
    check(iss_ready == 1'b0, "R6", "ready during flush", iss_ready, 0);
    @(posedge clk);
    #1;
    while (q.size() > 0 && q[q.size()-1].due >= cyc) void'(q.pop_back());
    flush = 1'b0; iss_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (fin_valid) begin
        if (q.size() == 0) begin
          check(1'b0, "R7", "unexpected finish tag", int'(fin_tag), -1);
        end else begin
          exp_t it;
          it = q.pop_front();
          check(fin_tag == it.tag, it.req, "finish tag", int'(fin_tag), int'(it.tag));
          check(cyc == it.due, it.req, "finish cycle", cyc, it.due);
          check(fin_exc == it.exc, "R5", "exception flag", int'(fin_exc), int'(it.exc));
        end
      end else if (q.size() > 0 && q[0].due <= cyc) begin
        check(1'b0, q[0].req, "missing finish at cycle", cyc, q[0].due);
        void'(q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WD_MAX) begin
      errors++;
      $display("FAIL R7 watchdog: actual cycle %0d expected below %0d", cyc, WD_MAX);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a0, a1;
    repeat (3) @(posedge clk);
    #1;
    check(fin_valid == 1'b0, "R1", "fin_valid in reset", fin_valid, 0);
    check(iss_ready == 1'b1, "R1", "ready in reset", iss_ready, 1);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(fin_valid == 1'b0, "R1", "fin_valid after reset", fin_valid, 0);
    check(iss_ready == 1'b1, "R8", "ready when empty", iss_ready, 1);

    // R2: back-to-back single precision, including the spare code
    issue(2'b00, 6'd1, 1'b0, "R2", a0);
    for (int i = 2; i < 7; i++) begin
      issue((i == 4) ? 2'b11 : 2'b00, TAG_W'(i), i[0], "R2", a1);
      check(a1 == a0 + 1, "R2", "sp acceptance gap", a1 - a0, 1);
      a0 = a1;
    end
    idle(4);

    // R3: double multiply holds two cycles
    issue(2'b01, 6'd10, 1'b1, "R3", a0);
    issue(2'b01, 6'd11, 1'b0, "R3", a1);
    check(a1 == a0 + 2, "R3", "dp to dp gap", a1 - a0, 2);
    issue(2'b00, 6'd12, 1'b0, "R7", a0);
    check(a0 == a1 + 2, "R3", "dp to sp gap", a0 - a1, 2);
    idle(5);

    // R4: divide holds DIV_CYC cycles
    issue(2'b10, 6'd20, 1'b1, "R4", a0);
    issue(2'b00, 6'd21, 1'b0, "R7", a1);
    check(a1 == a0 + DIV_CYC, "R4", "div to sp gap", a1 - a0, DIV_CYC);
    issue(2'b10, 6'd22, 1'b0, "R4", a0);
    check(a0 == a1 + 1, "R8", "sp then div gap", a0 - a1, 1);
    idle(DIV_CYC + 4);

    // R6: flush with every stage occupied
    issue(2'b00, 6'd30, 1'b0, "R6", a0);
    issue(2'b00, 6'd31, 1'b0, "R6", a0);
    issue(2'b00, 6'd32, 1'b0, "R6", a0);
    flush_now();
    #1;
    check(fin_valid == 1'b0, "R6", "fin after flush", fin_valid, 0);
    idle(6);

    // R6: flush in the middle of a divide, then normal issue resumes
    issue(2'b10, 6'd40, 1'b1, "R6", a0);
    idle(5);
    flush_now();
    @(negedge clk);
    #1;
    check(iss_ready == 1'b1, "R6", "ready after flush", iss_ready, 1);
    issue(2'b00, 6'd41, 1'b1, "R5", a1);
    idle(DIV_CYC + 4);

    // R7: mixed classes keep order
    issue(2'b01, 6'd50, 1'b0, "R7", a0);
    issue(2'b00, 6'd51, 1'b1, "R7", a0);
    issue(2'b11, 6'd52, 1'b0, "R7", a0);
    issue(2'b01, 6'd53, 1'b1, "R7", a0);
    issue(2'b00, 6'd54, 1'b0, "R7", a0);
    idle(10);

    check(q.size() == 0, "R7", "leftover expectations", q.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule